// File: doc/BRIEF.md
# Selectable-Response Three-Tap Fixed-Point Filter

This block filters a stream of 14-bit signed fractional samples through a second-order (three-tap) FIR structure. It offers four fixed responses, chosen at run time: smoothing (low-pass), edge emphasis (high-pass), a band-pass and a band-stop. Every coefficient is a signed power of two (0, ±0.25 or ±0.5). Each product is therefore a sign-extended arithmetic shift and never a multiplier.

A producer presents one sample with a valid strobe. The block keeps the two previous accepted samples and registers the three scaled terms. It then adds them in a widened accumulator, rounds, clamps to the 14-bit range and registers the result with its own valid flag. Idle cycles leave both the sample history and the output untouched. A change of response applies from the next accepted sample and keeps the sample history.

Top module: `fir4_bank`

## Requirements
- R1: Reset clears the output word, the output valid flag and both history registers. The first sample after reset is filtered as if the two earlier samples were zero.
- R2: `out_valid` pulses exactly two clock edges after the edge that accepts a sample with `in_valid` high, once per accepted sample.
- R3: While `in_valid` is low, the history does not shift and `out_data` holds its value, whatever `in_data` and `resp_sel` carry.
- R4: With `resp_sel` = 00 (low-pass), the output is 0.25·x[n] + 0.5·x[n-1] + 0.25·x[n-2].
- R5: With `resp_sel` = 01 (high-pass), the output is -0.25·x[n] + 0.5·x[n-1] - 0.25·x[n-2].
- R6: With `resp_sel` = 10 (band-pass), the output is -0.5·x[n] + 0.5·x[n-2].
- R7: With `resp_sel` = 11 (band-stop), the output is 0.5·x[n] + 0.5·x[n-2].
- R8: The sum is held in units of 2^-15. It is rounded to units of 2^-13 by adding 2 and taking the floor of the quotient by 4, so an exact half rounds toward plus infinity.
- R9: A rounded result above +8191 is output as +8191, and one below -8192 as -8192. The result never wraps.
- R10: The response select is sampled together with each accepted sample. Switching it does not clear or alter the sample history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Input sample, two's complement, 13 fraction bits |
| resp_sel | input | 2 | Response: 00 low, 01 high, 10 band-pass, 11 band-stop |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 14 | Filtered sample, two's complement, 13 fraction bits |

## Verification
The bench builds the block with its default 14-bit sample width and two extra fraction bits. With these values the full signed range is small enough to step through every response in fine increments. Every ordered triple of seven extreme values (both limits, their neighbours and zero) is also applied in each mode. Within this configuration the only reachable clamp is at the positive limit, and the sweep reaches it from both the high-pass and the band-pass response. The sweep also produces many exact-half ties in the rounding step, of both signs. Random idle gaps carrying garbage, mode switches on every sample and a reset part way through the run cover the history and hold behaviour.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  typedef enum logic [1:0] {
    RESP_LOW  = 2'b00,
    RESP_HIGH = 2'b01,
    RESP_BAND = 2'b10,
    RESP_STOP = 2'b11
  } resp_e;

  localparam int unsigned NUM_TAPS = 3;

  // One tap weight: active selects a nonzero weight, half picks 0.5 over
  // 0.25, negate flips the sign.
  typedef struct packed {
    logic active;
    logic negate;
    logic half;
  } tap_w_t;

  function automatic tap_w_t tap_weight(input resp_e r, input int unsigned idx);
    tap_w_t w;
    w = '{active: 1'b1, negate: 1'b0, half: 1'b0};
    case (r)
      RESP_LOW: begin
        w.half = (idx == 1);
      end
      RESP_HIGH: begin
        w.half   = (idx == 1);
        w.negate = (idx != 1);
      end
      RESP_BAND: begin
        w.active = (idx != 1);
        w.half   = 1'b1;
        w.negate = (idx == 0);
      end
      default: begin
        w.active = (idx != 1);
        w.half   = 1'b1;
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fir4_delay_line.sv
module fir4_delay_line #(
  parameter int unsigned W = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] d1,
  output logic signed [W-1:0] d2
);

  always_ff @(posedge clk) begin
    if (rst) begin
      d1 <= '0;
      d2 <= '0;
    end else if (adv) begin
      d1 <= din;
      d2 <= d1;
    end
  end

endmodule

// File: rtl/fir4_tap_scaler.sv
module fir4_tap_scaler
  import fir4_pkg::*;
#(
  parameter int unsigned W        = 14,
  parameter int unsigned FRAC_EXT = 2,
  parameter int unsigned ACC_W    = W + FRAC_EXT + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [W-1:0]     x,
  input  tap_w_t                  wt,
  output logic signed [ACC_W-1:0] prod
);

  localparam int unsigned SIGN_EXT = ACC_W - W - FRAC_EXT;

  // Align the sample to the wider fraction grid, then shift right with the
  // sign copied into the vacated high bits.
  function automatic logic signed [ACC_W-1:0] scale(
    input logic signed [W-1:0] s,
    input tap_w_t              c
  );
    logic signed [ACC_W-1:0] aligned;
    logic signed [ACC_W-1:0] shifted;
    aligned = {{SIGN_EXT{s[W-1]}}, s, {FRAC_EXT{1'b0}}};
    shifted = c.half ? (aligned >>> 1) : (aligned >>> 2);
    if (!c.active) return '0;
    return c.negate ? -shifted : shifted;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       prod <= '0;
    else if (load) prod <= scale(x, wt);
  end

endmodule

// File: rtl/fir4_sum_out.sv
module fir4_sum_out #(
  parameter int unsigned W        = 14,
  parameter int unsigned FRAC_EXT = 2,
  parameter int unsigned ACC_W    = W + FRAC_EXT + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] p0,
  input  logic signed [ACC_W-1:0] p1,
  input  logic signed [ACC_W-1:0] p2,
  output logic                    sat_hi,
  output logic                    sat_lo,
  output logic                    out_valid,
  output logic signed [W-1:0]     out_data
);

  localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_EXT - 1));
  localparam logic signed [ACC_W-1:0] TOP = ACC_W'((1 << (W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] BOT = ~TOP;

  function automatic logic signed [ACC_W-1:0] round_down(
    input logic signed [ACC_W-1:0] s
  );
    return (s + RND) >>> FRAC_EXT;
  endfunction

  logic signed [ACC_W-1:0] total;
  logic signed [ACC_W-1:0] rounded;

  assign total   = p0 + p1 + p2;
  assign rounded = round_down(total);
  assign sat_hi  = rounded > TOP;
  assign sat_lo  = rounded < BOT;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= load;
      if (load) begin
        if (sat_hi)      out_data <= TOP[W-1:0];
        else if (sat_lo) out_data <= BOT[W-1:0];
        else             out_data <= rounded[W-1:0];
      end
    end
  end

endmodule

// File: rtl/fir4_bank.sv
module fir4_bank
  import fir4_pkg::*;
#(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned FRAC_EXT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        resp_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned ACC_W = DATA_W + FRAC_EXT + 1;

  logic signed [DATA_W-1:0] tap_x [NUM_TAPS];
  logic signed [ACC_W-1:0]  prod  [NUM_TAPS];
  logic signed [DATA_W-1:0] hist1, hist2;
  logic signed [DATA_W-1:0] res_data;
  logic                     prod_valid;
  logic                     sat_hi, sat_lo;

  fir4_delay_line #(.W(DATA_W)) u_delay (
    .clk (clk),
    .rst (rst),
    .adv (in_valid),
    .din (signed'(in_data)),
    .d1  (hist1),
    .d2  (hist2)
  );

  assign tap_x[0] = signed'(in_data);
  assign tap_x[1] = hist1;
  assign tap_x[2] = hist2;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    tap_w_t wt;
    assign wt = tap_weight(resp_e'(resp_sel), i);
    fir4_tap_scaler #(.W(DATA_W), .FRAC_EXT(FRAC_EXT), .ACC_W(ACC_W)) u_scale (
      .clk  (clk),
      .rst  (rst),
      .load (in_valid),
      .x    (tap_x[i]),
      .wt   (wt),
      .prod (prod[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prod_valid <= 1'b0;
    else     prod_valid <= in_valid;
  end

  fir4_sum_out #(.W(DATA_W), .FRAC_EXT(FRAC_EXT), .ACC_W(ACC_W)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .load      (prod_valid),
    .p0        (prod[0]),
    .p1        (prod[1]),
    .p2        (prod[2]),
    .sat_hi    (sat_hi),
    .sat_lo    (sat_lo),
    .out_valid (out_valid),
    .out_data  (res_data)
  );

  assign out_data = res_data;

endmodule

// File: rtl/fir4_bank_chk.sv
module fir4_bank_chk #(
  parameter int unsigned DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [DATA_W-1:0] hist1,
  input logic [DATA_W-1:0] hist2,
  input logic              prod_valid,
  input logic              sat_hi,
  input logic              sat_lo,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  localparam logic [DATA_W-1:0] TOP_W = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] BOT_W = {1'b1, {(DATA_W-1){1'b0}}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && hist1 == '0 && hist2 == '0));

  assert_accept_stage_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prod_valid);

  assert_out_follows_R2: assert property (@(posedge clk) disable iff (rst)
    prod_valid |=> out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !prod_valid |=> !out_valid);

  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(hist1) && $stable(hist2)));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !prod_valid |=> $stable(out_data));

  assert_hist_shift_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (hist1 == $past(in_data) && hist2 == $past(hist1)));

  assert_clamp_top_R9: assert property (@(posedge clk) disable iff (rst)
    (prod_valid && sat_hi) |=> out_data == TOP_W);

  assert_clamp_bot_R9: assert property (@(posedge clk) disable iff (rst)
    (prod_valid && sat_lo) |=> out_data == BOT_W);

  always_comb begin
    assert_clamp_exclusive_R9: assert (!(sat_hi && sat_lo));
  end

endmodule

bind fir4_bank fir4_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .hist1      (hist1),
  .hist2      (hist2),
  .prod_valid (prod_valid),
  .sat_hi     (sat_hi),
  .sat_lo     (sat_lo),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/fir4_bank_tb.sv
module fir4_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 14;
  localparam int XMAX = 8191;
  localparam int XMIN = -8192;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [1:0]   resp_sel = 2'b00;
  logic         out_valid;
  logic [W-1:0] out_data;

  fir4_bank u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .resp_sel  (resp_sel),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_run = 0, n_fail = 0;
  int    h1 = 0, h2 = 0;
  int    last_mode = -1;
  bit    fresh = 1'b1;
  int    exp_q[$];
  int    cyc_q[$];
  string tag_q[$];
  int    last_out = 0;

  task automatic check(input string req, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Weights in quarters: rows are modes 00 low, 01 high, 10 band-pass, 11 band-stop.
  function automatic int wq(input int m, input int t);
    case (m)
      0: return (t == 1) ? 2 : 1;
      1: return (t == 1) ? 2 : -1;
      2: return (t == 0) ? -2 : ((t == 2) ? 2 : 0);
      default: return (t == 1) ? 0 : 2;
    endcase
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic send(input int m, input int x);
    int acc, t, r, q;
    string tag;
    @(negedge clk);
    in_valid = 1'b1;
    resp_sel = 2'(m);
    in_data  = W'(x);
    acc = wq(m, 0) * x + wq(m, 1) * h1 + wq(m, 2) * h2;  // units of 2^-15
    t = acc + 2;
    r = ((t % 4) + 4) % 4;
    q = (t - r) / 4;                                      // floor division
    case (m)
      0: tag = "R4";
      1: tag = "R5";
      2: tag = "R6";
      default: tag = "R7";
    endcase
    if (r == 0 && ((acc % 4) + 4) % 4 == 2) tag = {tag, " R8"};
    if (q > XMAX) begin q = XMAX; tag = {tag, " R9"}; end
    if (q < XMIN) begin q = XMIN; tag = {tag, " R9"}; end
    if (fresh) tag = {tag, " R1"};
    if (last_mode >= 0 && last_mode != m) tag = {tag, " R10"};
    exp_q.push_back(q);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
    h2 = h1;
    h1 = x;
    last_mode = m;
    fresh = 1'b0;
  endtask

  // Idle cycles carry garbage on the data and mode inputs (R3).
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = W'($urandom);
      resp_sel = 2'($urandom);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_data after reset", int'(out_data), 0);
    rst = 1'b0;
    h1 = 0;
    h2 = 0;
    fresh = 1'b1;
    last_mode = -1;
    exp_q.delete();
    cyc_q.delete();
    tag_q.delete();
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 output without accepted sample", 1, 0);
        end else begin
          int    e, c;
          string tg;
          e  = exp_q.pop_front();
          c  = cyc_q.pop_front();
          tg = tag_q.pop_front();
          check(tg, int'($signed(out_data)), e);
          check("R2 latency", cyc - c, 2);
        end
      end else begin
        check("R3 output hold while idle", int'($signed(out_data)), last_out);
      end
    end
    last_out = int'($signed(out_data));
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int edges[7];
    edges = '{XMIN, XMIN + 1, -1, 0, 1, XMAX - 1, XMAX};
    repeat (2) @(negedge clk);
    do_reset();

    // R1: first sample sees a zero history
    send(0, XMAX);
    idle(3);

    // R9: positive clamp from band-pass and from high-pass
    send(2, XMAX); send(2, 0); send(2, XMIN);
    idle(2);
    send(1, XMIN); send(1, XMAX); send(1, XMIN);
    idle(2);

    // R8: exact-half ties of both signs in low-pass
    send(0, 0); send(0, 0); send(0, 2); send(0, 0); send(0, 0); send(0, -2);
    idle(3);

    // R4..R7: sweep each response across the range with random gaps (R3)
    for (int m = 0; m < 4; m++) begin
      for (int v = XMIN; v <= XMAX; v += 37) begin
        send(m, v);
        if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
      end
      idle(2);
    end

    // Every ordered triple of extreme values in each response
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++)
          for (int c = 0; c < 7; c++) begin
            send(m, edges[a]); send(m, edges[b]); send(m, edges[c]);
          end
      idle(2);
    end

    // R10: response switched on every sample, history carried across
    for (int k = 0; k < 200; k++) begin
      send(k % 4, int'($urandom_range(0, 16383)) - 8192);
      if (k % 9 == 0) idle(1);
    end
    idle(3);

    // R1: reset in the middle of a stream clears history
    send(3, XMAX); send(3, XMAX);
    do_reset();
    send(3, XMAX);
    send(2, 100);
    idle(4);

    check("R2 every accepted sample produced an output", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule